// File: doc/BRIEF.md
# Two-Port Parallel I/O Peripheral

This block gives software two 8-bit general-purpose ports on a strobe-timed peripheral bus. The bus carries a word address, a write flag, a select line, an access strobe and a shared bidirectional 8-bit data bus. Each port has a data register and a direction register. The register values go straight to pad-facing output and active-low output-enable lines. A read of a data register returns the external pin levels after they pass through a synchronizer.

The two ports use opposite direction polarity. A port A pin is an output when its direction bit is 1. A port B pin is an output when its direction bit is 0. After reset, port A is therefore all inputs and port B drives zeros on every pin. The strobe is sampled in the system clock domain. A write commits on the first clock edge that sees the strobe low after it was high, provided select and the write flag are high at that edge.

Top module: `pio_dual_port`

## Requirements
- R1: While rst_ni is low, every data and direction register is 0. This gives pa_out_o=0x00, pa_oe_no=0xFF, pb_out_o=0x00 and pb_oe_no=0x00.
- R2: A write commits at the first rising clock edge where stb_i is low after being high at the previous edge, with sel_i=1 and wr_i=1. The new value appears on the register outputs right after that edge and not before it.
- R3: When sel_i is low, a strobe has no effect on any register.
- R4: Registers are decoded from the word index addr_i (the address bits [6:2]). Index 0 is port A data, 1 is port B data, 2 is port A direction and 3 is port B direction. Any other index reads as 0x00 and ignores writes.
- R5: pa_oe_no is the bitwise inverse of the port A direction register, so direction bit 1 enables the output.
- R6: pb_oe_no equals the port B direction register, so direction bit 0 enables the output.
- R7: pa_out_o and pb_out_o always carry the value of their port's data register.
- R8: A read of index 0 or 1 returns that port's pin input, delayed by two clock flops, and not the written value. A pin change made before rising edge k is readable after edge k+1.
- R9: A read of index 2 or 3 returns the direction register value.
- R10: data_io is driven only while sel_i=1, wr_i=0 and stb_i=1. During a write cycle the block leaves the bus to the bus master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| addr_i | input | 5 | Word index (address bits [6:2]) |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| sel_i | input | 1 | Block select |
| stb_i | input | 1 | Access strobe |
| data_io | inout | 8 | Shared bidirectional data bus |
| pa_out_o | output | 8 | Port A output values |
| pa_oe_no | output | 8 | Port A output enables, active low |
| pa_in_i | input | 8 | Port A pin levels |
| pb_out_o | output | 8 | Port B output values |
| pb_oe_no | output | 8 | Port B output enables, active low |
| pb_in_i | input | 8 | Port B pin levels |

## Verification
A write commits at the rising edge where the strobe is first seen low. The bench checks the pad outputs one half-cycle before that edge, where they must still hold the old value, and one half-cycle after it, where they must hold the new value. Read data is combinational from registers, so it is sampled 1 ns after the strobe rises. A pin change is synchronized through two flops. The bench therefore changes pins on a falling edge and reads after one rising edge, expecting the old level. It then reads after a second rising edge, expecting the new level. All inputs change on falling edges.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    REG_A_DATA = 2'd0,
    REG_B_DATA = 2'd1,
    REG_A_DIR  = 2'd2,
    REG_B_DIR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic b_dir;
    logic a_dir;
    logic b_data;
    logic a_data;
  } wr_stb_t;
endpackage

// File: rtl/pio_bus_ctrl.sv
module pio_bus_ctrl
  import pio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic              stb_i,
  output wr_stb_t           we_o,
  output reg_sel_e          rsel_o,
  output logic              hit_o,
  output logic              rd_en_o
);
  localparam int UPPER_W = ADDR_W - 2;

  logic stb_q;
  logic stb_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_i;
  end

  assign stb_fall = stb_q & ~stb_i;
  assign hit_o    = (addr_i[ADDR_W-1:2] == UPPER_W'(0));
  assign rsel_o   = reg_sel_e'(addr_i[1:0]);
  assign rd_en_o  = sel_i & ~wr_i & stb_i;

  always_comb begin
    we_o = '0;
    if (stb_fall && sel_i && wr_i && hit_o) begin
      unique case (rsel_o)
        REG_A_DATA: we_o.a_data = 1'b1;
        REG_B_DATA: we_o.b_data = 1'b1;
        REG_A_DIR:  we_o.a_dir  = 1'b1;
        REG_B_DIR:  we_o.b_dir  = 1'b1;
      endcase
    end
  end

  // R4
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));
  // R3
  we_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |-> (sel_i && wr_i));
  // R2
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |=> !(|we_o));
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R8
  sync_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> stage_q[0] == $past(d_i));
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int WIDTH      = 8,
  parameter bit DIR_ONE_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_we_i,
  input  logic             dir_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_q_o,
  output logic [WIDTH-1:0] dir_q_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_no
);
  logic [WIDTH-1:0] data_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_we_i) data_q <= wdata_i;
      if (dir_we_i)  dir_q  <= wdata_i;
    end
  end

  if (DIR_ONE_OUT) begin : g_dir_hi
    assign oe_no = ~dir_q;
  end else begin : g_dir_lo
    assign oe_no = dir_q;
  end

  assign out_o    = data_q;
  assign data_q_o = data_q;
  assign dir_q_o  = dir_q;

  // R2
  data_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> data_q == $past(wdata_i));
  // R2
  dir_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> dir_q == $past(wdata_i));
  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i |=> $stable(data_q));
  // R3
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_we_i |=> $stable(dir_q));
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic              stb_i,
  inout  wire  [PORT_W-1:0] data_io,
  output logic [PORT_W-1:0] pa_out_o,
  output logic [PORT_W-1:0] pa_oe_no,
  input  logic [PORT_W-1:0] pa_in_i,
  output logic [PORT_W-1:0] pb_out_o,
  output logic [PORT_W-1:0] pb_oe_no,
  input  logic [PORT_W-1:0] pb_in_i
);
  wr_stb_t          we;
  reg_sel_e         rsel;
  logic             hit, rd_en;
  logic [PORT_W-1:0] wdata, rdata;
  logic [PORT_W-1:0] pa_data, pa_dir, pb_data, pb_dir;
  logic [PORT_W-1:0] pa_sync, pb_sync;

  assign wdata = data_io;

  pio_bus_ctrl #(.ADDR_W(ADDR_W)) i_bus (
    .clk_i, .rst_ni, .addr_i, .wr_i, .sel_i, .stb_i,
    .we_o(we), .rsel_o(rsel), .hit_o(hit), .rd_en_o(rd_en)
  );

  pio_port #(.WIDTH(PORT_W), .DIR_ONE_OUT(1'b1)) i_port_a (
    .clk_i, .rst_ni,
    .data_we_i(we.a_data), .dir_we_i(we.a_dir), .wdata_i(wdata),
    .data_q_o(pa_data), .dir_q_o(pa_dir), .out_o(pa_out_o), .oe_no(pa_oe_no)
  );

  pio_port #(.WIDTH(PORT_W), .DIR_ONE_OUT(1'b0)) i_port_b (
    .clk_i, .rst_ni,
    .data_we_i(we.b_data), .dir_we_i(we.b_dir), .wdata_i(wdata),
    .data_q_o(pb_data), .dir_q_o(pb_dir), .out_o(pb_out_o), .oe_no(pb_oe_no)
  );

  pio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync_a (
    .clk_i, .rst_ni, .d_i(pa_in_i), .q_o(pa_sync)
  );

  pio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync_b (
    .clk_i, .rst_ni, .d_i(pb_in_i), .q_o(pb_sync)
  );

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (rsel)
        REG_A_DATA: rdata = pa_sync;
        REG_B_DATA: rdata = pb_sync;
        REG_A_DIR:  rdata = pa_dir;
        REG_B_DIR:  rdata = pb_dir;
      endcase
    end
  end

  assign data_io = rd_en ? rdata : {PORT_W{1'bz}};

  // R7
  pa_out_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pa_data) |-> $stable(pa_out_o));
  // R5
  pa_dir_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(pa_dir) |-> $changed(pa_oe_no));
endmodule

// File: tb/test_pio_dual_port.sv
module test_pio_dual_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [4:0]   addr = '0;
  logic         wr = 1'b0, sel = 1'b0, stb = 1'b0;
  logic [W-1:0] pa_in = '0, pb_in = '0;
  logic [W-1:0] pa_out, pa_oe_n, pb_out, pb_oe_n;
  logic [W-1:0] tb_wdata = '0;
  logic         tb_drive = 1'b0;
  wire  [W-1:0] bus_w;
  int checks = 0, errors = 0;
  logic [W-1:0] rd;

  assign bus_w = tb_drive ? tb_wdata : {W{1'bz}};

  always #2 clk = ~clk;

  pio_dual_port i_pio_dual_port (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .sel_i(sel),
    .stb_i(stb), .data_io(bus_w),
    .pa_out_o(pa_out), .pa_oe_no(pa_oe_n), .pa_in_i(pa_in),
    .pb_out_o(pb_out), .pb_oe_no(pb_oe_n), .pb_in_i(pb_in)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge; commit edge is between the 2nd and 3rd
  task automatic bus_write(logic [4:0] a, logic [W-1:0] d, logic s);
    addr = a; wr = 1'b1; sel = s; tb_wdata = d; tb_drive = 1'b1; stb = 1'b1;
    #1 check("R10 bus free in write", bus_w, d);
    @(negedge clk); stb = 1'b0;
    @(negedge clk); sel = 1'b0; wr = 1'b0; tb_drive = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [W-1:0] d);
    addr = a; wr = 1'b0; sel = 1'b1; stb = 1'b1;
    #1 d = bus_w;
    @(negedge clk); stb = 1'b0; sel = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pa_oe_n", pa_oe_n, 8'hFF);
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 pb_oe_n", pb_oe_n, 8'h00);
  endtask

  task automatic t_write_timing;
    addr = 5'd0; wr = 1'b1; sel = 1'b1; tb_wdata = 8'hC3; tb_drive = 1'b1; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    check("R2 before commit", pa_out, 8'h00);
    @(negedge clk); sel = 1'b0; wr = 1'b0; tb_drive = 1'b0;
    check("R2 after commit", pa_out, 8'hC3);
    check("R7 pa_out data", pa_out, 8'hC3);
  endtask

  task automatic t_directions;
    bus_write(5'd2, 8'h0F, 1'b1);
    check("R5 pa_oe_n", pa_oe_n, 8'hF0);
    bus_write(5'd3, 8'h3C, 1'b1);
    check("R6 pb_oe_n", pb_oe_n, 8'h3C);
    bus_write(5'd1, 8'hA5, 1'b1);
    check("R7 pb_out data", pb_out, 8'hA5);
    bus_read(5'd2, rd); check("R9 A dir read", rd, 8'h0F);
    bus_read(5'd3, rd); check("R9 B dir read", rd, 8'h3C);
  endtask

  task automatic t_sel_low;
    bus_write(5'd0, 8'h11, 1'b0);
    bus_write(5'd2, 8'hFF, 1'b0);
    check("R3 pa_out unchanged", pa_out, 8'hC3);
    check("R3 pa_oe_n unchanged", pa_oe_n, 8'hF0);
  endtask

  task automatic t_unmapped;
    bus_write(5'd4, 8'hFF, 1'b1);
    bus_write(5'd31, 8'hFF, 1'b1);
    bus_read(5'd4, rd); check("R4 unmapped read", rd, 8'h00);
    bus_read(5'd2, rd); check("R4 A dir kept", rd, 8'h0F);
    bus_read(5'd3, rd); check("R4 B dir kept", rd, 8'h3C);
    check("R4 pa_out kept", pa_out, 8'hC3);
    check("R4 pb_out kept", pb_out, 8'hA5);
  endtask

  task automatic t_pin_read;
    pa_in = 8'h5A; pb_in = 8'h96;
    @(negedge clk);
    bus_read(5'd0, rd); check("R8 A one edge old", rd, 8'h00);
    bus_read(5'd0, rd); check("R8 A pins not written", rd, 8'h5A);
    bus_read(5'd1, rd); check("R8 B pins", rd, 8'h96);
    pb_in = 8'h01;
    @(negedge clk);
    bus_read(5'd1, rd); check("R8 B one edge old", rd, 8'h96);
    bus_read(5'd1, rd); check("R8 B new level", rd, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_write_timing();
    t_directions();
    t_sel_low();
    t_unmapped();
    t_pin_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule